// File: doc/BRIEF.md
# Register Load/Store Instruction Unit

This unit carries out a two-word load or store instruction for the command processor of an I/O controller. It moves between one and four bytes between a 128-byte internal register file and system memory. An upstream fetch stage hands it both instruction words. The unit forms the effective memory address, checks it against the transfer rules, and then issues one 32-bit memory beat with byte enables over a request/acknowledge interface. A load writes the returned lanes into the register file. A store drives the register contents onto the write data lanes.

The effective address comes from one of two sources. In absolute mode it is the second instruction word. In relative mode it is a data-structure base value plus that word, and the 32-bit sum wraps. A register byte always occupies the same byte lane as its memory byte. Because a transfer may not cross a 4-byte boundary, every legal instruction completes in a single bus beat. If an instruction breaks any rule, the unit reports a one-cycle error and does nothing else.

Top module: `ldst_unit`

## Requirements
- R1: After synchronous reset, `mem_req`, `done` and `err` are low and `ins_ready` is high.
- R2: The beat address is the effective address with its two low bits cleared. When bit 28 of the first word is 1, the effective address is `base_addr + ins_w1` modulo 2^32. When bit 28 is 0, it is `ins_w1`.
- R3: The byte count sits in bits 2:0 of the first word. A count of 0 or of 5 to 7 is illegal.
- R4: The register address sits in bits 22:16. An instruction is illegal when bits 1:0 of the register address differ from bits 1:0 of the effective address.
- R5: An instruction is illegal when address bits 1:0 plus the count exceed 4.
- R6: An instruction is illegal when bits 31:7 of the effective address equal bits 31:7 of `WIN_BASE`, the unit's own 128-byte register window.
- R7: For a legal instruction, `mem_be` bit i is set exactly for lanes i from address[1:0] to address[1:0]+count-1. Bit 24 of the first word gives the direction: 1 means load, so `mem_we`=0, and 0 means store, so `mem_we`=1.
- R8: A store drives each enabled lane i with register byte {regaddr[6:2], i}. Lanes that are not enabled are driven with zero.
- R9: A load writes each enabled lane of `mem_rdata` into register {regaddr[6:2], i}. All other registers are left unchanged.
- R10: Register `RO_REG` (default 7'h0D) is read-only. A load leaves it unchanged, and a store returns `ro_stat` in its lane.
- R11: Once raised, `mem_req` stays high with a stable address until `mem_ack` is seen. `done` then pulses for one cycle, the cycle after the acknowledge. `ins_ready` is high only when the unit is idle.
- R12: An illegal instruction raises `err` for exactly one cycle, two cycles after it is accepted. It raises no `mem_req` and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction words are valid |
| ins_ready | output | 1 | Unit is idle and accepts an instruction |
| ins_w0 | input | 32 | First word: mode, direction, register address, count |
| ins_w1 | input | 32 | Second word: address or offset |
| base_addr | input | 32 | Data-structure base for relative mode |
| ro_stat | input | 8 | Current value of the read-only register |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat (store) |
| mem_addr | output | 32 | Word-aligned beat address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Beat completed |
| mem_rdata | input | 32 | Load data, valid with `mem_ack` |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rule-violation pulse |

## Verification
Decode and lane state are held in registers, so a fault in them appears two cycles after acceptance. It shows as a wrong `mem_be`, `mem_addr` or `err` choice. A corrupted register file stays hidden until a later store of the same word, where it shows as wrong lane data. The bench therefore loads the whole file first, then stores words back after every load and every error case. A handshake fault shows within one cycle as `mem_req` dropping early or `done` lasting too long.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int LANES   = 4;
  localparam int LANE_W  = 8;
  localparam int WORD_W  = LANES * LANE_W;
  localparam int CNT_W   = 3;
  localparam int REL_BIT = 28;
  localparam int DIR_BIT = 24;
  localparam int RA_LSB  = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CHK  = 2'd1,
    ST_BUS  = 2'd2
  } st_e;
endpackage

// File: rtl/ldst_check.sv
module ldst_check
  import ldst_pkg::*;
#(
  parameter int              AW       = 32,
  parameter int              RAW      = 7,
  parameter logic [AW-1:0]   WIN_BASE = 32'h0000_1000
) (
  input  logic [AW-1:0]    ea,
  input  logic [RAW-1:0]   ra,
  input  logic [CNT_W-1:0] cnt,
  output logic             ok,
  output logic [LANES-1:0] be
);
  logic [3:0] lo;
  logic [3:0] span;
  logic       cnt_ok, lane_ok, edge_ok, win_hit;

  assign lo      = {2'b00, ea[1:0]};
  assign span    = lo + {1'b0, cnt};
  assign cnt_ok  = (cnt != '0) && (cnt <= CNT_W'(LANES));
  assign lane_ok = (ra[1:0] == ea[1:0]);
  assign edge_ok = (span <= 4'(LANES));
  assign win_hit = (ea[AW-1:RAW] == WIN_BASE[AW-1:RAW]);
  assign ok      = cnt_ok && lane_ok && edge_ok && !win_hit;

  for (genvar i = 0; i < LANES; i++) begin : g_be
    assign be[i] = (4'(i) >= lo) && (4'(i) < span);
  end
endmodule

// File: rtl/ldst_regfile.sv
module ldst_regfile
  import ldst_pkg::*;
#(
  parameter int WAW = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [WAW-1:0]    waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WAW-1:0]    raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << WAW;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int i = 0; i < LANES; i++) begin
        if (be[i]) mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
      end
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int              AW       = 32,
  parameter int              RAW      = 7,
  parameter logic [AW-1:0]   WIN_BASE = 32'h0000_1000,
  parameter logic [RAW-1:0]  RO_REG   = 7'h0D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [31:0]       ins_w0,
  input  logic [AW-1:0]     ins_w1,
  input  logic [AW-1:0]     base_addr,
  input  logic [LANE_W-1:0] ro_stat,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic              err
);
  localparam int WAW = RAW - 2;

  st_e              st;
  logic [AW-1:0]    ea_q;
  logic [RAW-1:0]   ra_q;
  logic [CNT_W-1:0] cnt_q;
  logic             load_q;
  logic             accept;
  logic             chk_ok;
  logic [LANES-1:0] chk_be;
  logic [WORD_W-1:0] rd_q;
  logic [WORD_W-1:0] st_word;
  logic [LANES-1:0]  ro_mask;
  logic              ro_word;
  logic              rf_we;
  logic              unused_bits;

  assign unused_bits = ^{ins_w0[31:29], ins_w0[27:25], ins_w0[23], ins_w0[15:3]};
  assign ins_ready   = (st == ST_IDLE);
  assign accept      = ins_valid && ins_ready;

  ldst_check #(.AW(AW), .RAW(RAW), .WIN_BASE(WIN_BASE)) u_check (
    .ea (ea_q),
    .ra (ra_q),
    .cnt(cnt_q),
    .ok (chk_ok),
    .be (chk_be)
  );

  assign ro_word = (ra_q[RAW-1:2] == RO_REG[RAW-1:2]);

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      ro_mask[i] = ro_word && (RO_REG[1:0] == 2'(i));
      st_word[i*LANE_W +: LANE_W] = '0;
      if (chk_be[i]) begin
        st_word[i*LANE_W +: LANE_W] = ro_mask[i] ? ro_stat : rd_q[i*LANE_W +: LANE_W];
      end
    end
  end

  assign rf_we = (st == ST_BUS) && mem_ack && load_q;

  ldst_regfile #(.WAW(WAW)) u_rf (
    .clk  (clk),
    .we   (rf_we),
    .be   (mem_be & ~ro_mask),
    .waddr(ra_q[RAW-1:2]),
    .wdata(mem_rdata),
    .raddr(ins_w0[RA_LSB+2 +: WAW]),
    .rdata(rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ea_q      <= '0;
      ra_q      <= '0;
      cnt_q     <= '0;
      load_q    <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            ea_q   <= ins_w0[REL_BIT] ? (base_addr + ins_w1) : ins_w1;
            ra_q   <= ins_w0[RA_LSB +: RAW];
            cnt_q  <= ins_w0[CNT_W-1:0];
            load_q <= ins_w0[DIR_BIT];
            st     <= ST_CHK;
          end
        end
        ST_CHK: begin
          if (chk_ok) begin
            mem_req   <= 1'b1;
            mem_we    <= !load_q;
            mem_addr  <= {ea_q[AW-1:2], 2'b00};
            mem_be    <= chk_be;
            mem_wdata <= st_word;
            st        <= ST_BUS;
          end else begin
            err <= 1'b1;
            st  <= ST_IDLE;
          end
        end
        ST_BUS: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            done    <= 1'b1;
            st      <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldst_unit_chk.sv
module ldst_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        ins_ready,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic        done,
  input logic        err
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  // R12
  err_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (!mem_req && !done));

  // R7
  be_contig_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_be inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'h6, 4'hC, 4'h7, 4'hE, 4'hF}));

  // R11
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !ins_ready);
endmodule

bind ldst_unit ldst_unit_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .ins_ready(ins_ready),
  .mem_req  (mem_req),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .mem_be   (mem_be),
  .done     (done),
  .err      (err)
);

// File: tb/ldst_unit_bench.sv
`timescale 1ns/1ps
module ldst_unit_bench;
  localparam logic [31:0] WIN  = 32'h0000_1000;
  localparam logic [6:0]  RO   = 7'h0D;
  localparam logic [7:0]  STAT = 8'hA5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [31:0] ins_w0 = '0, ins_w1 = '0, base_addr = '0;
  logic [7:0]  ro_stat = STAT;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0]  mem_be;
  logic        done, err;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [128];

  always #4 clk = ~clk;

  ldst_unit u_ldst_unit (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_w0(ins_w0), .ins_w1(ins_w1), .base_addr(base_addr), .ro_stat(ro_stat),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .err(err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_instr(input logic load, input logic rel, input logic [6:0] ra,
                          input int cnt, input logic [31:0] w1, input logic [31:0] base,
                          input logic [31:0] rdata, input int delay, input string tag);
    logic [31:0] ea, exp_wd;
    logic [3:0]  exp_be;
    int          off;
    bit          legal;
    ea  = rel ? base + w1 : w1;
    off = int'(ea[1:0]);
    legal = (cnt >= 1) && (cnt <= 4) && (ra[1:0] == ea[1:0]) && (off + cnt <= 4)
            && (ea[31:7] != WIN[31:7]);
    exp_be = '0;
    exp_wd = '0;
    for (int i = 0; i < 4; i++) begin
      if (i >= off && i < off + cnt) begin
        exp_be[i] = 1'b1;
        exp_wd[i*8 +: 8] = ({ra[6:2], 2'(i)} == RO) ? STAT : model[{ra[6:2], 2'(i)}];
      end
    end
    @(negedge clk);
    check({"R11 ready idle ", tag}, 32'(ins_ready), 32'd1);
    ins_w0 = (32'(rel) << 28) | (32'(load) << 24) | (32'(ra) << 16) | 32'(cnt[2:0]);
    ins_w1 = w1;
    base_addr = base;
    ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
    check({"R11 ready busy ", tag}, 32'(ins_ready), 32'd0);
    @(negedge clk);
    if (!legal) begin
      check({"R3-6 err pulse ", tag}, {30'd0, err, mem_req}, 32'h2);
      @(negedge clk);
      check({"R12 err one cycle ", tag}, {30'd0, err, mem_req}, 32'h0);
    end else begin
      check({"R12 no err ", tag}, 32'(err), 32'd0);
      check({"R2 addr ", tag}, mem_addr, {ea[31:2], 2'b00});
      check({"R7 be ", tag}, 32'(mem_be), 32'(exp_be));
      check({"R7 dir ", tag}, {30'd0, mem_req, mem_we}, {30'd0, 1'b1, !load});
      if (!load) check({"R8 wdata ", tag}, mem_wdata, exp_wd);
      for (int d = 0; d < delay; d++) begin
        @(negedge clk);
        check({"R11 req held ", tag}, {30'd0, mem_req, done}, 32'h2);
      end
      mem_ack = 1'b1;
      mem_rdata = rdata;
      @(negedge clk);
      mem_ack = 1'b0;
      mem_rdata = '0;
      check({"R11 done ", tag}, {30'd0, done, mem_req}, 32'h2);
      @(negedge clk);
      check({"R11 done one cycle ", tag}, 32'(done), 32'd0);
      if (load) begin
        for (int i = 0; i < 4; i++) begin
          if (exp_be[i] && ({ra[6:2], 2'(i)} != RO)) model[{ra[6:2], 2'(i)}] = rdata[i*8 +: 8];
        end
      end
    end
  endtask

  task automatic verify_word(input logic [6:0] ra, input string tag);
    do_instr(1'b0, 1'b0, {ra[6:2], 2'b00}, 4, 32'h0000_3000, 32'h0, 32'h0, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {28'd0, mem_req, done, err, ins_ready}, 32'h1);
    rst = 1'b0;
    // R9: fill the register file
    for (int k = 0; k < 32; k++) begin
      do_instr(1'b1, 1'b0, 7'(k * 4), 4, 32'h0000_2000 + 32'(k * 4),
               32'h0, 32'h1020_3040 + 32'(k) * 32'h0101_0101, 0, "R9 fill");
    end
    // R10: read-only byte returns status
    verify_word(7'h0C, "R10 ro store");
    do_instr(1'b1, 1'b0, 7'h0D, 1, 32'h0000_2101, 32'h0, 32'hFFFF_FFFF, 0, "R10 ro load");
    verify_word(7'h0C, "R10 ro unchanged");
    // R7 R8: partial store
    do_instr(1'b0, 1'b0, 7'h06, 2, 32'h0000_3002, 32'h0, 32'h0, 0, "R8 upper half");
    // R2 R9: relative partial load
    do_instr(1'b1, 1'b1, 7'h11, 3, 32'h0000_2001, 32'h0000_0100, 32'hDEAD_BEEF, 0, "R9 rel load");
    verify_word(7'h10, "R9 neighbours kept");
    // R2: wrap
    do_instr(1'b0, 1'b1, 7'h00, 1, 32'h0000_0014, 32'hFFFF_FFF8, 32'h0, 1, "R2 wrap");
    // R11: delayed ack
    do_instr(1'b1, 1'b0, 7'h22, 2, 32'h0000_4002, 32'h0, 32'h1234_5678, 3, "R11 slow ack");
    verify_word(7'h20, "R11 after slow");
    // Errors
    do_instr(1'b1, 1'b0, 7'h40, 0, 32'h0000_2000, 32'h0, 32'h0, 0, "R3 cnt0");
    do_instr(1'b1, 1'b0, 7'h40, 5, 32'h0000_2000, 32'h0, 32'h0, 0, "R3 cnt5");
    do_instr(1'b1, 1'b0, 7'h41, 1, 32'h0000_2002, 32'h0, 32'h0, 0, "R4 lane");
    do_instr(1'b1, 1'b0, 7'h43, 2, 32'h0000_2003, 32'h0, 32'h0, 0, "R5 cross");
    do_instr(1'b1, 1'b0, 7'h40, 4, 32'h0000_1040, 32'h0, 32'h0, 0, "R6 abs window");
    do_instr(1'b0, 1'b1, 7'h40, 4, 32'h0000_007C, WIN, 32'h0, 0, "R6 rel window");
    verify_word(7'h40, "R12 no change");
    do_instr(1'b1, 1'b0, 7'h43, 1, 32'h0000_2003, 32'h0, 32'hAB00_0000, 0, "R5 edge ok");
    verify_word(7'h40, "R9 last lane");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule